// File: doc/BRIEF.md
# Core Regulator Power-Good Sequencer

This block drives the two power-good indications of a core voltage regulator. One is an active-low "good" flag. The other is a delayed, active-high "good" flag that follows it. The block also drives a boot-complete signal that hands reference control to the programmed code.

The analog window comparators sit outside the block. They supply an in-window flag (core within ±14% of the reference) and a boot-reached flag. The block also takes a microsecond tick, a switching-cycle tick, and a strobe that pulses whenever the reference code or the sleep state changes.

Start-up runs in two stages. First, the boot-reached flag must hold for a dwell of microsecond ticks; only then does the active-low flag assert. The delayed flag asserts a fixed number of switching cycles later. Once running, a reference change blanks both flags for a fixed number of switching cycles. During blanking the active-low flag is forced low and the delayed flag is forced high, whatever the window state. Dropping enable or entering undervoltage discards all progress.

Top module: `pgood_seq`

## Requirements
- R1: While `en` is low or `uv` is high, `pg_n` is 1, `pg_del` is 0 and `boot_done` is 0. All dwell, delay and blanking progress is cleared, so a later start begins from the beginning.
- R2: After a start, `pg_n` stays 1 until `boot_ok` has been high on BOOT_US (default 10) consecutive clock edges that carry `us_tick`. Any edge with `boot_ok` low restarts this count.
- R3: After the boot dwell and outside blanking, `pg_n` is 0 when `in_win` is 1 and 1 when `in_win` is 0.
- R4: `pg_del` goes to 1 only once DEL_CYC (default 1007) `cyc_tick` edges have been counted with `in_win` high since the boot dwell ended. After that, and outside blanking, `pg_del` equals `in_win`.
- R5: After the boot dwell, a `ref_chg` edge starts blanking that lasts for BLANK_CYC (default 62) further `cyc_tick` edges. Edges without `cyc_tick` do not shorten it. A strobe on the same edge as a tick takes precedence.
- R6: During blanking, `pg_n` is 0 and `pg_del` is 1 regardless of `in_win`.
- R7: A `ref_chg` that arrives during blanking restarts the full BLANK_CYC count.
- R8: If `in_win` is low on an edge outside blanking before `pg_del` has first asserted, the delay count returns to zero.
- R9: `boot_done` rises on the edge that completes the boot dwell, which is the first edge on which `pg_n` can assert. It stays 1 until R1 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Regulator enable, active high |
| uv | input | 1 | Supply undervoltage status, active high |
| in_win | input | 1 | Core voltage inside the good window |
| boot_ok | input | 1 | Core voltage has reached the boot level |
| us_tick | input | 1 | One-clock pulse per microsecond |
| cyc_tick | input | 1 | One-clock pulse per switching cycle |
| ref_chg | input | 1 | One-clock strobe on a code or sleep change |
| pg_n | output | 1 | Active-low power-good |
| pg_del | output | 1 | Delayed active-high power-good |
| boot_done | output | 1 | Boot dwell complete; code controls the reference |

## Verification
The bench interrupts the boot dwell partway through and checks that an off-by-one or non-restarting dwell counter releases `pg_n` one edge early. It drops the window midway through the 1007-cycle delay and probes `pg_del` at edge 1006 and edge 1007 after re-entry. A counter that only pauses would assert early, and one off by one would miss the exact edge. Blanking is probed at its last and first-free edges, with a second strobe mid-count and with ticks stopped, so that a timer that ignores the restart, counts clocks instead of ticks, or swaps the forced polarities shows up. Finally, undervoltage is applied and released to show that `boot_done` and the dwell really start over.

// File: rtl/pgs_pkg.sv
package pgs_pkg;

    typedef enum logic [1:0] {
        PH_OFF  = 2'd0,
        PH_BOOT = 2'd1,
        PH_RUN  = 2'd2
    } phase_e;

    typedef struct packed {
        logic pg_n;
        logic pg_del;
        logic boot_done;
    } pg_out_t;

    localparam pg_out_t PG_IDLE = '{pg_n: 1'b1, pg_del: 1'b0, boot_done: 1'b0};

    function automatic int cnt_w(input int limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction

endpackage

// File: rtl/pgs_boot_dwell.sv
module pgs_boot_dwell
    import pgs_pkg::*;
#(
    parameter int BOOT_US = 10
) (
    input  logic clk,
    input  logic rst,
    input  logic active,
    input  logic boot_ok,
    input  logic us_tick,
    output logic booted
);
    localparam int W = cnt_w(BOOT_US);
    localparam logic [W-1:0] LAST = W'(BOOT_US - 1);

    phase_e       ph;
    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !active) begin
            ph  <= PH_OFF;
            cnt <= '0;
        end else if (ph != PH_RUN) begin
            ph <= PH_BOOT;
            if (!boot_ok) begin
                cnt <= '0;
            end else if (us_tick) begin
                if (cnt == LAST) begin
                    ph  <= PH_RUN;
                    cnt <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assign booted = (ph == PH_RUN);

    assert_boot_dwell_met_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(booted) |-> $past(boot_ok && us_tick && active));

    assert_boot_needs_level_R2: assert property (@(posedge clk) disable iff (rst)
        (active && !booted && !boot_ok) |=> (cnt == '0) && !booted);

endmodule

// File: rtl/pgs_blank_timer.sv
module pgs_blank_timer #(
    parameter int BLANK_CYC = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic ref_chg,
    input  logic cyc_tick,
    output logic blanking
);
    generate
        if (BLANK_CYC == 0) begin : g_none
            assign blanking = 1'b0;
        end else begin : g_cnt
            localparam int W = pgs_pkg::cnt_w(BLANK_CYC);
            logic [W-1:0] left;

            always_ff @(posedge clk) begin
                if (rst || !armed) begin
                    left <= '0;
                end else if (ref_chg) begin
                    left <= W'(BLANK_CYC);
                end else if (cyc_tick && left != '0) begin
                    left <= left - 1'b1;
                end
            end

            assign blanking = (left != '0);

            assert_strobe_blanks_R5: assert property (@(posedge clk) disable iff (rst)
                (armed && ref_chg) |=> (blanking || !armed));

            assert_restart_full_R7: assert property (@(posedge clk) disable iff (rst)
                (armed && ref_chg) |=> (left == W'(BLANK_CYC)) || !armed);

            assert_hold_no_tick_R5: assert property (@(posedge clk) disable iff (rst)
                (armed && blanking && !cyc_tick) |=> (blanking || !armed));
        end
    endgenerate

endmodule

// File: rtl/pgs_pgdel_timer.sv
module pgs_pgdel_timer #(
    parameter int DEL_CYC = 1007
) (
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic hold,
    input  logic in_win,
    input  logic cyc_tick,
    output logic del_done
);
    localparam int W = pgs_pkg::cnt_w(DEL_CYC);
    localparam logic [W-1:0] LAST = W'(DEL_CYC - 1);

    logic [W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !armed) begin
            cnt      <= '0;
            del_done <= 1'b0;
        end else if (!del_done && !hold) begin
            if (!in_win) begin
                cnt <= '0;
            end else if (cyc_tick) begin
                if (cnt == LAST) begin
                    cnt      <= '0;
                    del_done <= 1'b1;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    assert_count_restart_R8: assert property (@(posedge clk) disable iff (rst)
        (armed && !del_done && !hold && !in_win) |=> (cnt == '0) && !del_done);

    assert_done_on_tick_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(del_done) |-> $past(in_win && cyc_tick && armed));

endmodule

// File: rtl/pgood_seq.sv
module pgood_seq
    import pgs_pkg::*;
#(
    parameter int BOOT_US   = 10,
    parameter int DEL_CYC   = 1007,
    parameter int BLANK_CYC = 62
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic uv,
    input  logic in_win,
    input  logic boot_ok,
    input  logic us_tick,
    input  logic cyc_tick,
    input  logic ref_chg,
    output logic pg_n,
    output logic pg_del,
    output logic boot_done
);
    logic    active;
    logic    booted;
    logic    armed;
    logic    blanking;
    logic    del_done;
    pg_out_t outs;

    assign active = en && !uv;
    assign armed  = active && booted;

    pgs_boot_dwell #(.BOOT_US(BOOT_US)) i_boot (
        .clk     (clk),
        .rst     (rst),
        .active  (active),
        .boot_ok (boot_ok),
        .us_tick (us_tick),
        .booted  (booted)
    );

    pgs_blank_timer #(.BLANK_CYC(BLANK_CYC)) i_blank (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .ref_chg  (ref_chg),
        .cyc_tick (cyc_tick),
        .blanking (blanking)
    );

    pgs_pgdel_timer #(.DEL_CYC(DEL_CYC)) i_del (
        .clk      (clk),
        .rst      (rst),
        .armed    (armed),
        .hold     (blanking),
        .in_win   (in_win),
        .cyc_tick (cyc_tick),
        .del_done (del_done)
    );

    always_comb begin
        outs = PG_IDLE;
        if (armed) begin
            outs.boot_done = 1'b1;
            if (blanking) begin
                outs.pg_n   = 1'b0;
                outs.pg_del = 1'b1;
            end else begin
                outs.pg_n   = !in_win;
                outs.pg_del = del_done && in_win;
            end
        end
    end

    assign pg_n      = outs.pg_n;
    assign pg_del    = outs.pg_del;
    assign boot_done = outs.boot_done;

    assert_idle_when_off_R1: assert property (@(posedge clk) disable iff (rst)
        !active |-> (pg_n && !pg_del && !boot_done));

    assert_blank_polarity_R6: assert property (@(posedge clk) disable iff (rst)
        blanking |-> (!pg_n && pg_del));

    assert_boot_done_sticky_R9: assert property (@(posedge clk) disable iff (rst)
        (boot_done && active) |=> (boot_done || !active));

endmodule

// File: tb/test_pgood_seq.sv
module test_pgood_seq;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en = 1'b0, uv = 1'b0, in_win = 1'b0, boot_ok = 1'b0;
    logic us_tick = 1'b0, cyc_tick = 1'b0, ref_chg = 1'b0;
    logic pg_n, pg_del, boot_done;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    always #10 clk = ~clk;

    pgood_seq i_pgood_seq (
        .clk(clk), .rst(rst), .en(en), .uv(uv), .in_win(in_win),
        .boot_ok(boot_ok), .us_tick(us_tick), .cyc_tick(cyc_tick),
        .ref_chg(ref_chg), .pg_n(pg_n), .pg_del(pg_del), .boot_done(boot_done)
    );

    // rows: {in_win, exp pg_n, exp pg_del, exp boot_done} in steady running state
    localparam logic [3:0] VEC [3] = '{4'b1011, 4'b0101, 4'b1011};

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        #5;
    endtask

    task automatic chk(input string req, input logic [2:0] exp);
        logic [2:0] got;
        #1;
        got = {pg_n, pg_del, boot_done};
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {pg_n,pg_del,boot_done} actual %b expected %b at %0t",
                     req, got, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 20);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        step(2);
        chk("R1 reset", 3'b100);
        rst = 1'b0;
        step(1);
        chk("R1 disabled", 3'b100);

        // R2: dwell not started while boot_ok low
        en = 1'b1; in_win = 1'b1; us_tick = 1'b1;
        step(20);
        chk("R2 no boot level", 3'b100);
        // R2: interrupted dwell restarts
        boot_ok = 1'b1;
        step(5);
        boot_ok = 1'b0;
        step(1);
        boot_ok = 1'b1;
        step(9);
        chk("R2 dwell edge 9", 3'b100);
        step(1);
        chk("R9 boot_done with pg_n", 3'b001);

        // R8: leaving window mid-delay resets the count
        cyc_tick = 1'b1;
        step(500);
        chk("R4 delay running", 3'b001);
        in_win = 1'b0;
        step(1);
        chk("R3 out of window", 3'b101);
        in_win = 1'b1;
        step(1006);
        chk("R8 restarted delay edge 1006", 3'b001);
        step(1);
        chk("R4 delayed good at 1007", 3'b011);

        // R5/R6 blanking length and polarity
        ref_chg = 1'b1;
        step(1);
        ref_chg = 1'b0; in_win = 1'b0;
        chk("R6 forced polarity", 3'b011);
        step(61);
        chk("R5 last blank edge", 3'b011);
        step(1);
        chk("R5 blank over", 3'b101);

        // R7 restart by second strobe
        in_win = 1'b1;
        ref_chg = 1'b1;
        step(1);
        ref_chg = 1'b0;
        step(30);
        ref_chg = 1'b1;
        step(1);
        ref_chg = 1'b0; in_win = 1'b0;
        step(61);
        chk("R7 restarted blank", 3'b011);
        step(1);
        chk("R7 blank over", 3'b101);

        // R5 no ticks: blanking holds
        ref_chg = 1'b1; cyc_tick = 1'b0;
        step(1);
        ref_chg = 1'b0;
        step(100);
        chk("R5 holds without ticks", 3'b011);
        cyc_tick = 1'b1;
        step(62);
        chk("R5 ends after ticks", 3'b101);

        // steady-state vector table
        for (int i = 0; i < 3; i++) begin
            in_win = VEC[i][3];
            step(3);
            chk("R3 R4 steady table", VEC[i][2:0]);
        end

        // R1 undervoltage clears everything
        uv = 1'b1;
        step(1);
        chk("R1 undervoltage", 3'b100);
        uv = 1'b0; boot_ok = 1'b0;
        step(3);
        chk("R1 R9 restart after uv", 3'b100);
        boot_ok = 1'b1;
        step(10);
        chk("R2 new dwell", 3'b001);
        en = 1'b0;
        step(1);
        chk("R1 enable low", 3'b100);

        finish_run();
    end
endmodule